// File: doc/BRIEF.md
# External Register Bus Master with Wait States

This block connects a processor core to a small bank of 16-bit registers that live outside the core. It places a 3-bit register address on an address bus and marks the access with an active-low data strobe. A direction line says whether the core reads or writes. On writes it drives the 16-bit data bus; on reads it releases the bus and takes the value the peripheral returns.

By default an access finishes in the same cycle it is requested. A core-side configuration bit adds a fixed internal wait. A slow peripheral can stretch the access further by pulling the active-low wait input low. That input matters only while an access is on the bus.

The core side is a valid/ready request channel. The core raises `req_valid` with address, direction and write data, and must hold all of them unchanged until it sees `req_ready` high at a rising edge. Every cycle in which `req_ready` stays low is a stall cycle. Read results come back on a response strobe `rsp_valid` with no back-pressure: `rsp_valid` is high for one cycle, and the core must take `rsp_rdata` in that cycle.

Top module: `extbus_master`

## Requirements
- R1: While `req_valid` is low, `bus_ds_n` is 1, `bus_data_oe` is 0 and `req_ready` is 0.
- R2: With `cfg_wait_en`=0 and `bus_wait_n` high, `req_ready` is 1 in the first cycle of the access, so the transfer takes one cycle.
- R3: With `cfg_wait_en`=1, the first cycle of every access has `req_ready`=0. With `bus_wait_n` high, the access completes in exactly its second cycle.
- R4: In any cycle of an access where `bus_wait_n` is low, `req_ready` is 0. The access completes in the first cycle in which `bus_wait_n` is high and no internal wait remains.
- R5: `bus_wait_n` has no effect outside an access: with `req_valid` low, toggling it changes none of the outputs.
- R6: `bus_data_oe` is 1 only in cycles of a write access (`req_write`=1), and then `bus_data_o` equals `req_wdata`. In every other cycle the bus is released.
- R7: For a read, `rsp_rdata` holds the value of `bus_data_i` from the completing cycle, and `rsp_valid` is 1 in the following cycle only. Writes produce no `rsp_valid`.
- R8: During every cycle of an access, `bus_ds_n` is 0, `bus_addr` equals `req_addr`, and `bus_rnw` is 1 for a read and 0 for a write.
- R9: The core is stalled (`req_ready`=0) in every cycle by which the access is extended beyond its first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait_en | input | 1 | Enables the internal wait |
| req_valid | input | 1 | Core access request |
| req_ready | output | 1 | Access completes this cycle; low means stall |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | External register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 16 | Captured read data |
| bus_addr | output | 3 | External address bus |
| bus_ds_n | output | 1 | Active-low data strobe |
| bus_rnw | output | 1 | Direction: 1 read, 0 write |
| bus_wait_n | input | 1 | Active-low wait from the peripheral |
| bus_data_o | output | 16 | Data bus output value |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_data_i | input | 16 | Data bus input value |

## Verification
The bench builds the block with its default parameters: a 3-bit address, 16-bit data and one internal wait cycle. With these values, every combination of the internal wait and external stretching can be reached within a few cycles. This covers the cases where the external wait ends before the internal one, at the same cycle, and after it. The read source changes its value every cycle, so capturing the data in the wrong cycle shows up as a wrong value.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/extbus_waitgen.sv
module extbus_waitgen #(
  parameter int INT_WAIT_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cfg_wait_en,
  input  logic ext_wait_n,
  output logic done
);
  localparam int CW = $clog2(INT_WAIT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(INT_WAIT_CYC);

  logic [CW-1:0] spent;
  logic          int_pending;

  assign int_pending = cfg_wait_en && (spent < LIM);
  assign done        = active && !int_pending && ext_wait_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      spent <= '0;
    else if (done || !active)
      spent <= '0;
    else if (spent != LIM)
      spent <= spent + 1'b1;
  end
endmodule

// File: rtl/extbus_pins.sv
module extbus_pins
  import extbus_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          active,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ds_n,
  output logic          bus_rnw,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe
);
  bus_dir_e dir;

  always_comb begin
    dir         = write ? DIR_WRITE : DIR_READ;
    bus_ds_n    = !active;
    bus_addr    = active ? addr : '0;
    bus_rnw     = active ? (dir == DIR_READ) : 1'b1;
    bus_data_oe = active && (dir == DIR_WRITE);
    bus_data_o  = bus_data_oe ? wdata : '0;
  end
endmodule

// File: rtl/extbus_capture.sv
module extbus_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_rdata <= din;
    end
  end
endmodule

// File: rtl/extbus_master.sv
module extbus_master #(
  parameter int AW           = 3,
  parameter int DW           = 16,
  parameter int INT_WAIT_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wait_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ds_n,
  output logic          bus_rnw,
  input  logic          bus_wait_n,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe,
  input  logic [DW-1:0] bus_data_i
);
  logic done;

  extbus_waitgen #(.INT_WAIT_CYC(INT_WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(req_valid),
    .cfg_wait_en(cfg_wait_en), .ext_wait_n(bus_wait_n), .done(done)
  );

  extbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .active(req_valid), .write(req_write), .addr(req_addr), .wdata(req_wdata),
    .bus_addr(bus_addr), .bus_ds_n(bus_ds_n), .bus_rnw(bus_rnw),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe)
  );

  extbus_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(done && !req_write), .din(bus_data_i),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign req_ready = done;
endmodule

// File: rtl/extbus_master_chk.sv
module extbus_master_chk #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wait_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ds_n,
  input logic          bus_rnw,
  input logic          bus_wait_n,
  input logic [DW-1:0] bus_data_o,
  input logic          bus_data_oe,
  input logic [DW-1:0] bus_data_i
);
  logic cont;
  logic start;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cont <= 1'b0;
    else        cont <= req_valid && !req_ready;
  end
  assign start = req_valid && !cont;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (bus_ds_n && !bus_data_oe && !req_ready));
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cfg_wait_en && bus_wait_n) |-> req_ready);
  a_r3_first_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_wait_en) |-> !req_ready);
  a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_wait_n) |-> !req_ready);
  a_r6_drive_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (req_valid && req_write && bus_data_o == req_wdata));
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_write) |=> (rsp_valid && rsp_rdata == $past(bus_data_i)));
  a_r7_no_write_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_write) |=> !rsp_valid);
  a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (!bus_ds_n && bus_addr == req_addr && bus_rnw == !req_write));
endmodule

bind extbus_master extbus_master_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_extbus_master.sv
module sim_extbus_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_wait_en = 0, req_valid = 0, req_write = 0, bus_wait_n = 1;
  logic [2:0]  req_addr = 0;
  logic [15:0] req_wdata = 0, bus_data_i = 0;
  logic        req_ready, rsp_valid, bus_ds_n, bus_rnw, bus_data_oe;
  logic [15:0] rsp_rdata, bus_data_o;
  logic [2:0]  bus_addr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extbus_master u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One access; external wait held low for the first nlow cycles.
  task automatic access(input logic wr, input logic [2:0] a, input logic [15:0] d,
                        input logic cfg, input int nlow);
    int last = (cfg ? 1 : 0) > nlow ? (cfg ? 1 : 0) : nlow;
    logic [15:0] exp_rd = 0;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      cfg_wait_en = cfg; req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      bus_wait_n = (k >= nlow);
      bus_data_i = d ^ 16'(k * 16'h0111);
      #1;
      chk("R8 strobe", {31'b0, bus_ds_n}, 0);
      chk("R8 addr", {29'b0, bus_addr}, {29'b0, a});
      chk("R8 rnw", {31'b0, bus_rnw}, {31'b0, !wr});
      chk("R6 oe", {31'b0, bus_data_oe}, {31'b0, wr});
      if (wr) chk("R6 data", {16'b0, bus_data_o}, {16'b0, d});
      if (k == last) begin
        chk(cfg && nlow == 0 ? "R3 ready" : (nlow > 0 ? "R4 ready" : "R2 ready"),
            {31'b0, req_ready}, 1);
        exp_rd = bus_data_i;
      end else
        chk(nlow > k ? "R4 stall" : "R9 stall", {31'b0, req_ready}, 0);
    end
    @(negedge clk);
    req_valid = 0; bus_wait_n = 1;
    #1;
    chk("R7 rsp_valid", {31'b0, rsp_valid}, {31'b0, !wr});
    if (!wr) chk("R7 rdata", {16'b0, rsp_rdata}, {16'b0, exp_rd});
    chk("R1 idle ds", {31'b0, bus_ds_n}, 1);
    @(negedge clk); #1;
    chk("R7 single pulse", {31'b0, rsp_valid}, 0);
  endtask

  task automatic idle_wait_toggle();
    logic [15:0] held;
    held = rsp_rdata;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bus_wait_n = k[0]; bus_data_i = 16'hDEAD + 16'(k);
      #1;
      chk("R5 ready", {31'b0, req_ready}, 0);
      chk("R5 ds", {31'b0, bus_ds_n}, 1);
      chk("R1 oe", {31'b0, bus_data_oe}, 0);
      chk("R5 rsp", {31'b0, rsp_valid}, 0);
      chk("R5 rdata", {16'b0, rsp_rdata}, {16'b0, held});
    end
    @(negedge clk); bus_wait_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset ds", {31'b0, bus_ds_n}, 1);
    chk("R1 reset rsp", {31'b0, rsp_valid}, 0);
    rst_n = 1;
    access(1, 3'd5, 16'hA55A, 0, 0);
    access(0, 3'd2, 16'h1234, 0, 0);
    access(1, 3'd7, 16'h0F0F, 1, 0);
    access(0, 3'd1, 16'hBEEF, 1, 0);
    access(0, 3'd3, 16'h4321, 0, 2);
    access(1, 3'd6, 16'h7777, 1, 1);
    access(0, 3'd4, 16'hC0DE, 1, 3);
    access(0, 3'd0, 16'h0001, 1, 1);
    idle_wait_toggle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule